// File: doc/BRIEF.md
# Dual Up-Counting Timer with Byte Reload

This block holds two independent up-counting timers, each made of a low byte and a high byte. A mode byte picks, for each timer, either a full 16-bit count that wraps to zero, or an 8-bit count in the low byte that refills itself from the high byte whenever it passes its top value. The refill needs no software action, so a fixed period follows from one setup write.

A control byte holds each timer's run bit and overflow flag. Each flag drives an interrupt request line. The flag clears when software writes a zero to it, or when the interrupt controller pulses the acknowledge line for that timer. A shared tick-enable input sets the count rate. All registers are written and read through one byte-wide port. A read returns the addressed register combinationally.

Top module: `dtmr_dual`

## Requirements
- R1: After reset every register reads 0x00 and both `irq` bits are 0.
- R2: A timer's count changes only on a clock where its run bit is 1 and `tick` is 1. Otherwise both of its bytes hold their value.
- R3: In 16-bit mode the pair {high,low} increments by one per counting clock, with a carry from the low byte into the high byte. From 0xFFFF it wraps to 0x0000 and sets that timer's flag.
- R4: In reload mode only the low byte counts. On a counting clock where it is 0xFF, it is loaded with the high byte instead and the flag is set. The high byte never changes by counting. With both bytes at 0xCE the flag is set once every 50 counting clocks.
- R5: Mode byte bits [1:0] select timer 0's mode and bits [5:4] select timer 1's mode. Value 2'b10 selects reload mode and every other value selects 16-bit mode. Writing 0x12 therefore puts timer 1 in 16-bit mode and timer 0 in reload mode.
- R6: Control byte layout: bit 4 is run 0, bit 5 is flag 0, bit 6 is run 1 and bit 7 is flag 1. Bits [3:0] read as 0 and ignore writes. `irq[i]` equals flag i.
- R7: A pulse on `irq_ack[i]` clears flag i on the next clock. If timer i overflows on that same clock, the flag stays set.
- R8: A control byte write loads both flags from the written value. If a timer overflows on the clock of the write, that timer's flag is set regardless of the written value.
- R9: A write to a count byte takes effect on the next clock. On that clock the timer does not count and does not overflow.
- R10: An acknowledge, overflow or count write for one timer leaves the other timer's flag and count unchanged.
- R11: Addresses: 0 is the mode byte, 1 is the control byte, 2 and 3 are timer 0 low and high, and 4 and 5 are timer 1 low and high. Addresses 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable for both timers |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Contents of the addressed register |
| irq_ack | input | 2 | Per-timer interrupt acknowledge pulse |
| irq | output | 2 | Per-timer interrupt request (overflow flag) |

## Verification
The hardest cases to reach are clocks where two sources drive the same state in one cycle. These are an overflow together with an acknowledge, an overflow together with a control write that clears the flag, and a count-byte write together with a counting tick. To reach them, the bench first parks a timer at 0xFFFF or at a chosen value while `tick` is low. It then raises `tick` on the same negative edge as the competing acknowledge or write, so both land on a single rising edge. The 50-clock reload period is measured by counting exact tick clocks from a fresh 0xCE reload to the next flag.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NUM_TMR = 2;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT0 = 3'd2;

    localparam int CTRL_RUN_BIT0  = 4;
    localparam int CTRL_FLAG_BIT0 = 5;
    localparam int MODE_NIB_W     = 4;

    typedef enum logic [1:0] {
        MD_WIDE_A = 2'b00,
        MD_WIDE   = 2'b01,
        MD_RELOAD = 2'b10,
        MD_WIDE_B = 2'b11
    } tmode_e;

    typedef struct packed {
        logic [BYTE_W-1:0]  mode;
        logic [NUM_TMR-1:0] run;
        logic [NUM_TMR-1:0] flag;
    } ctl_s;
endpackage

// File: rtl/dtmr_core.sv
module dtmr_core
    import dtmr_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  tmode_e        mode,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wr_data,
    output logic [BW-1:0] cnt_lo,
    output logic [BW-1:0] cnt_hi,
    output logic          ovf
);
    typedef struct packed {
        logic [BW-1:0] hi;
        logic [BW-1:0] lo;
    } cnt_t;

    cnt_t st_d, st_q;
    logic advance;

    always_comb begin
        st_d    = st_q;
        ovf     = 1'b0;
        advance = run && tick && !wr_lo && !wr_hi;
        if (wr_lo) st_d.lo = wr_data;
        if (wr_hi) st_d.hi = wr_data;
        if (advance) begin
            if (mode == MD_RELOAD) begin
                if (st_q.lo == '1) begin
                    st_d.lo = st_q.hi;
                    ovf     = 1'b1;
                end else begin
                    st_d.lo = st_q.lo + 1'b1;
                end
            end else begin
                st_d = st_q + 1'b1;
                ovf  = (st_q == '1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_lo = st_q.lo;
    assign cnt_hi = st_q.hi;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R2
    AST_WIDE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && mode != MD_RELOAD) |=> (cnt_lo == '0 && cnt_hi == '0)); // R3
    AST_RELOAD_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RELOAD && !wr_hi) |=> $stable(cnt_hi)); // R4
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && mode == MD_RELOAD) |=> (cnt_lo == $past(cnt_hi))); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt_lo == $past(wr_data))); // R9
    AST_NO_OVF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |-> !ovf); // R9
endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
    import dtmr_pkg::*;
#(
    parameter int BW = 8,
    parameter int NT = 2,
    parameter int AW = 3
) (
    input  logic [AW-1:0]        addr,
    input  logic [BW-1:0]        mode_byte,
    input  logic [BW-1:0]        ctrl_byte,
    input  logic [NT-1:0][BW-1:0] lo_bytes,
    input  logic [NT-1:0][BW-1:0] hi_bytes,
    output logic [BW-1:0]        rd_data
);
    always_comb begin
        rd_data = '0;
        if (addr == A_MODE) rd_data = mode_byte;
        if (addr == A_CTRL) rd_data = ctrl_byte;
        for (int i = 0; i < NT; i++) begin
            if (addr == AW'(int'(A_CNT0) + 2 * i))     rd_data = lo_bytes[i];
            if (addr == AW'(int'(A_CNT0) + 2 * i + 1)) rd_data = hi_bytes[i];
        end
    end
endmodule

// File: rtl/dtmr_dual.sv
module dtmr_dual
    import dtmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic [NUM_TMR-1:0] irq_ack,
    output logic [NUM_TMR-1:0] irq
);
    ctl_s ctl_d, ctl_q;

    logic [NUM_TMR-1:0]             ovf;
    logic [NUM_TMR-1:0]             wr_lo, wr_hi;
    logic [NUM_TMR-1:0][BYTE_W-1:0] lo_b, hi_b;
    logic [BYTE_W-1:0]              ctrl_byte;
    logic                           ctrl_wr;

    assign ctrl_wr = wr_en && (addr == A_CTRL);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && addr == A_MODE) ctl_d.mode = wr_data;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (irq_ack[i]) ctl_d.flag[i] = 1'b0;
            if (ctrl_wr) begin
                ctl_d.run[i]  = wr_data[CTRL_RUN_BIT0 + 2 * i];
                ctl_d.flag[i] = wr_data[CTRL_FLAG_BIT0 + 2 * i];
            end
            if (ovf[i]) ctl_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        ctrl_byte = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            ctrl_byte[CTRL_RUN_BIT0 + 2 * i]  = ctl_q.run[i];
            ctrl_byte[CTRL_FLAG_BIT0 + 2 * i] = ctl_q.flag[i];
        end
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        assign wr_lo[g] = wr_en && (addr == ADDR_W'(int'(A_CNT0) + 2 * g));
        assign wr_hi[g] = wr_en && (addr == ADDR_W'(int'(A_CNT0) + 2 * g + 1));

        dtmr_core #(.BW(BYTE_W)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .run     (ctl_q.run[g]),
            .mode    (tmode_e'(ctl_q.mode[MODE_NIB_W * g +: 2])),
            .wr_lo   (wr_lo[g]),
            .wr_hi   (wr_hi[g]),
            .wr_data (wr_data),
            .cnt_lo  (lo_b[g]),
            .cnt_hi  (hi_b[g]),
            .ovf     (ovf[g])
        );

        AST_FLAG_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[g] |=> irq[g]); // R7
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[g] && !ovf[g] && !ctrl_wr) |=> !irq[g]); // R7
        AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_ack[g] && !ovf[g] && !ctrl_wr) |=> $stable(irq[g])); // R10
    end

    dtmr_rdmux #(.BW(BYTE_W), .NT(NUM_TMR), .AW(ADDR_W)) u_rdmux (
        .addr      (addr),
        .mode_byte (ctl_q.mode),
        .ctrl_byte (ctrl_byte),
        .lo_bytes  (lo_b),
        .hi_bytes  (hi_b),
        .rd_data   (rd_data)
    );

    assign irq = ctl_q.flag;
endmodule

// File: tb/dtmr_dual_bench.sv
module dtmr_dual_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [1:0] irq_ack = 2'b00;
    logic [1:0] irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dtmr_dual u_dtmr_dual (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic with_tick);
        wr_en = 1'b1; addr = a; wr_data = d; tick = with_tick;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ack(input logic [1:0] m, input logic with_tick);
        irq_ack = m; tick = with_tick;
        @(negedge clk);
        irq_ack = 2'b00; tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", {8'h0, v}, 16'h0000);
        end
        chk("R1 reset irq", {14'h0, irq}, 16'h0000);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        wr(3'd2, 8'h05, 1'b0);
        ticks(3);
        rd(3'd2, v); chk("R2 no run", {8'h0, v}, 16'h0005);
        wr(3'd1, 8'h10, 1'b0);
        repeat (3) @(negedge clk);
        rd(3'd2, v); chk("R2 no tick", {8'h0, v}, 16'h0005);
        ticks(3);
        rd(3'd2, v); chk("R2 counting with mode 00", {8'h0, v}, 16'h0008);
    endtask

    task automatic t_wide;
        logic [7:0] lo, hi;
        wr(3'd1, 8'h00, 1'b0);
        wr(3'd0, 8'h01, 1'b0);
        wr(3'd2, 8'hFF, 1'b0);
        wr(3'd3, 8'h12, 1'b0);
        wr(3'd1, 8'h10, 1'b0);
        ticks(1);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R3 carry", {hi, lo}, 16'h1300);
        chk("R3 no flag on carry", {14'h0, irq}, 16'h0000);
        wr(3'd1, 8'h00, 1'b0);
        wr(3'd2, 8'hFD, 1'b0);
        wr(3'd3, 8'hFF, 1'b0);
        wr(3'd1, 8'h10, 1'b0);
        ticks(2);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R3 top value", {hi, lo}, 16'hFFFF);
        chk("R3 no flag before wrap", {14'h0, irq}, 16'h0000);
        ticks(1);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R3 wrap", {hi, lo}, 16'h0000);
        chk("R3 flag on wrap", {14'h0, irq}, 16'h0001);
    endtask

    task automatic t_reload;
        logic [7:0] lo, hi;
        wr(3'd1, 8'h00, 1'b0);
        wr(3'd0, 8'h02, 1'b0);
        wr(3'd2, 8'hCE, 1'b0);
        wr(3'd3, 8'hCE, 1'b0);
        wr(3'd1, 8'h10, 1'b0);
        ticks(49);
        rd(3'd2, lo);
        chk("R4 49 ticks", {8'h0, lo}, 16'h00FF);
        chk("R4 no flag at 49", {14'h0, irq}, 16'h0000);
        ticks(1);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R4 reload", {hi, lo}, 16'hCECE);
        chk("R4 flag at 50", {14'h0, irq}, 16'h0001);
        ack(2'b01, 1'b0);
        chk("R7 ack clears", {14'h0, irq}, 16'h0000);
        ticks(49);
        chk("R4 second period quiet", {14'h0, irq}, 16'h0000);
        ticks(1);
        chk("R4 second period flag", {14'h0, irq}, 16'h0001);
    endtask

    task automatic t_mixed;
        logic [7:0] v, lo, hi;
        wr(3'd1, 8'h00, 1'b0);
        wr(3'd0, 8'h12, 1'b0);
        wr(3'd2, 8'hFF, 1'b0);
        wr(3'd3, 8'h40, 1'b0);
        wr(3'd4, 8'hFF, 1'b0);
        wr(3'd5, 8'h00, 1'b0);
        wr(3'd1, 8'h50, 1'b0);
        ticks(1);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R5 timer0 reload mode", {hi, lo}, 16'h4040);
        rd(3'd4, lo); rd(3'd5, hi);
        chk("R5 timer1 wide mode", {hi, lo}, 16'h0100);
        rd(3'd1, v);
        chk("R6 control layout", {8'h0, v}, 16'h0070);
        chk("R10 only timer0 flag", {14'h0, irq}, 16'h0001);
        ack(2'b10, 1'b0);
        rd(3'd1, v);
        chk("R10 other ack ignored", {8'h0, v}, 16'h0070);
        ack(2'b01, 1'b0);
        rd(3'd1, v);
        chk("R7 own ack", {8'h0, v}, 16'h0050);
    endtask

    task automatic t_ack_race;
        logic [7:0] lo, hi;
        wr(3'd1, 8'h00, 1'b0);
        wr(3'd0, 8'h01, 1'b0);
        wr(3'd2, 8'hFF, 1'b0);
        wr(3'd3, 8'hFF, 1'b0);
        wr(3'd1, 8'h30, 1'b0);
        ack(2'b01, 1'b1);
        chk("R7 overflow beats ack", {14'h0, irq}, 16'h0001);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R7 count wrapped", {hi, lo}, 16'h0000);
    endtask

    task automatic t_sw_flag;
        logic [7:0] v;
        wr(3'd1, 8'hA0, 1'b0);
        chk("R8 software set", {14'h0, irq}, 16'h0003);
        rd(3'd1, v); chk("R6 flags readback", {8'h0, v}, 16'h00A0);
        wr(3'd1, 8'h0F, 1'b0);
        rd(3'd1, v); chk("R6 low nibble ignored", {8'h0, v}, 16'h0000);
        chk("R8 software clear", {14'h0, irq}, 16'h0000);
        wr(3'd0, 8'h01, 1'b0);
        wr(3'd2, 8'hFF, 1'b0);
        wr(3'd3, 8'hFF, 1'b0);
        wr(3'd1, 8'h10, 1'b0);
        wr(3'd1, 8'h10, 1'b1);
        rd(3'd1, v); chk("R8 overflow beats write", {8'h0, v}, 16'h0030);
    endtask

    task automatic t_override;
        logic [7:0] lo, hi;
        wr(3'd1, 8'h00, 1'b0);
        wr(3'd2, 8'h10, 1'b0);
        wr(3'd3, 8'h00, 1'b0);
        wr(3'd1, 8'h10, 1'b0);
        wr(3'd2, 8'h80, 1'b1);
        rd(3'd2, lo); chk("R9 write beats count", {8'h0, lo}, 16'h0080);
        wr(3'd2, 8'hFF, 1'b0);
        wr(3'd3, 8'hFF, 1'b0);
        wr(3'd3, 8'h05, 1'b1);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R9 high write stalls timer", {hi, lo}, 16'h05FF);
        chk("R9 no overflow on write", {14'h0, irq}, 16'h0000);
        rd(3'd6, lo); chk("R11 address 6", {8'h0, lo}, 16'h0000);
        rd(3'd7, lo); chk("R11 address 7", {8'h0, lo}, 16'h0000);
    endtask

    initial begin
        #200_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_wide();
        t_reload();
        t_mixed();
        t_ack_race();
        t_sw_flag();
        t_override();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule